// File: doc/BRIEF.md
# Averaging DC Level Threshold Monitor

The block accumulates a stream of signed ADC samples over a window whose length is a power of two. It divides the sum by the window length with an arithmetic shift and subtracts a stored reference offset. The difference is saturated to a signed 9-bit result, which is presented as a low byte plus a sign bit. The magnitude of each new result is compared with a high threshold and a low threshold. The two comparison outcomes are held as status bits.

A mode input chooses what a finished window does. In line mode (code 00) it updates the result and the status bits. In reference mode (code 01) it stores the average as the new offset and leaves the result and the status bits unchanged. Codes 10 and 11 are reserved and have no effect. An interrupt flag is set either when a status bit changes or after every finished measurement, depending on the interrupt-mode input. The flag is cleared by a read strobe.

In the target system each sample stands for one 143 us tick, so a window of N samples lasts N × 143 us. The ADC and the input channel multiplexer are outside the block.

Top module: `dc_level_monitor`

## Requirements
- R1: A window holds 2^k samples, where k is the position of the highest set bit of `window_i`, with a minimum of k = 1. A value of 0 or 1 therefore gives 2 samples, and 12 gives 8. `window_i` is captured with the first accepted sample of each window.
- R2: The average is the window sum shifted right arithmetically by k, which rounds toward minus infinity. In line mode the result is the average minus the stored offset, saturated to the range -256..255. `res_lo_o` carries result bits [7:0] in two's complement, and `res_sign_o` carries bit 8, which is 1 for negative results.
- R3: In line mode, `stat_hi_o` = (|result| >= high threshold) and `stat_lo_o` = (|result| >= low threshold). The magnitude of -256 is 256. The result, the status bits and the interrupt flag change at the rising edge that follows the edge accepting the last sample of a window.
- R4: After reset the result is 0 with sign 0, `stat_hi_o` is 0, `stat_lo_o` is 1, the interrupt flag is 0 and the stored offset is 0.
- R5: In reference mode (`mode_i` = 01) a finished window stores its average as the new offset, and the result and the status bits keep their values.
- R6: In the reserved modes (`mode_i` = 10 or 11) a finished window changes no output and no stored state, and it does not set the interrupt flag.
- R7: With `int_mode_i` = 0, the interrupt flag is set only by a line-mode result that changes at least one status bit.
- R8: With `int_mode_i` = 1, the interrupt flag is set after every window finished in line mode or reference mode, whether or not the status changed.
- R9: A pulse on `int_read_i` clears the interrupt flag at the next edge. If a set happens in the same cycle, the set wins.
- R10: The thresholds and the mode are captured with the first sample of a window. Changes to them during the window do not affect that window's result.
- R11: Samples are accepted only while `en_i` is high. Dropping `en_i` discards the partial window, and the next accepted sample starts a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Measurement enable |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W (10) | Signed ADC sample |
| window_i | input | WIN_W (8) | Window length in samples (power of two) |
| thr_hi_i | input | THR_W (8) | High magnitude threshold |
| thr_lo_i | input | THR_W (8) | Low magnitude threshold |
| mode_i | input | 2 | 00 line, 01 reference, 10/11 reserved |
| int_mode_i | input | 1 | 0 interrupt on status change, 1 on every result |
| int_read_i | input | 1 | Interrupt register read strobe |
| res_lo_o | output | RES_W-1 (8) | Result bits [7:0] |
| res_sign_o | output | 1 | Result sign bit |
| stat_hi_o | output | 1 | Magnitude at or above the high threshold |
| stat_lo_o | output | 1 | Magnitude at or above the low threshold |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench checks the rounding of negative averages. A design that truncates toward zero would report -40 instead of -41. It also checks saturation at both ends, including the -256 case whose magnitude needs a ninth bit; a wrapped or truncated result would flip the status bits. It uses a non-power-of-two window and a zero window, where a design that counted the raw value would never finish on time. It changes a threshold in the middle of a window, where a design that compared against the live input would raise the high bit and a false interrupt. Reference and reserved windows are run with every-result interrupts enabled, to catch a design that disturbs the result or signals a reserved window. An abandoned partial window is also checked, because leftover samples would skew the next average.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    MODE_LINE = 2'b00,
    MODE_REF  = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } dc_mode_e;
endpackage

// File: rtl/dcm_window_ctrl.sv
module dcm_window_ctrl #(
  parameter int WIN_W = 8,
  parameter int THR_W = 8,
  parameter int SH_W  = $clog2(WIN_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   valid_i,
  input  logic [WIN_W-1:0]       window_i,
  input  logic [THR_W-1:0]       thr_hi_i,
  input  logic [THR_W-1:0]       thr_lo_i,
  input  logic [1:0]             mode_i,
  output logic                   accept_o,
  output logic                   first_o,
  output logic                   last_o,
  output logic [SH_W-1:0]        shift_q_o,
  output logic [THR_W-1:0]       thr_hi_q_o,
  output logic [THR_W-1:0]       thr_lo_q_o,
  output dcm_pkg::dc_mode_e      mode_q_o
);
  localparam logic [WIN_W-1:0] ONE_W = {{(WIN_W-1){1'b0}}, 1'b1};

  // floor(log2(w)), at least 1
  function automatic logic [SH_W-1:0] win_log2(input logic [WIN_W-1:0] w);
    logic [SH_W-1:0] s;
    s = SH_W'(1);
    for (int i = 1; i < WIN_W; i++) if (w[i]) s = SH_W'(i);
    return s;
  endfunction

  logic [WIN_W-1:0] cnt_q, len_m1, len_q_m1;
  logic [SH_W-1:0]  sh_cur;

  assign accept_o = en_i & valid_i;
  assign first_o  = (cnt_q == '0);
  assign sh_cur   = first_o ? win_log2(window_i) : shift_q_o;
  assign len_m1   = (ONE_W << sh_cur) - ONE_W;
  assign len_q_m1 = (ONE_W << shift_q_o) - ONE_W;
  assign last_o   = accept_o & (cnt_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      shift_q_o  <= SH_W'(1);
      thr_hi_q_o <= '0;
      thr_lo_q_o <= '0;
      mode_q_o   <= dcm_pkg::MODE_LINE;
    end else begin
      if (!en_i)         cnt_q <= '0;
      else if (accept_o) cnt_q <= last_o ? '0 : cnt_q + ONE_W;
      if (accept_o && first_o) begin
        shift_q_o  <= sh_cur;
        thr_hi_q_o <= thr_hi_i;
        thr_lo_q_o <= thr_lo_i;
        mode_q_o   <= dcm_pkg::dc_mode_e'(mode_i);
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q <= len_q_m1));
endmodule

// File: rtl/dcm_accum.sv
module dcm_accum #(
  parameter int SAMPLE_W = 10,
  parameter int WIN_W    = 8,
  parameter int SH_W     = $clog2(WIN_W),
  parameter int ACC_W    = SAMPLE_W + WIN_W - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       accept_i,
  input  logic                       first_i,
  input  logic                       last_i,
  input  logic [SAMPLE_W-1:0]        sample_i,
  input  logic [SH_W-1:0]            shift_i,
  output logic signed [SAMPLE_W-1:0] avg_o,
  output logic                       done_o
);
  logic signed [ACC_W-1:0] acc_q, sample_x, scaled;

  assign sample_x = {{(ACC_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
  assign scaled   = acc_q >>> shift_i;
  assign avg_o    = scaled[SAMPLE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= accept_i & last_i;
      if (accept_i) acc_q <= first_i ? sample_x : acc_q + sample_x;
    end
  end

  // window is at least two samples long
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dcm_result.sv
module dcm_result #(
  parameter int SAMPLE_W = 10,
  parameter int RES_W    = 9,
  parameter int THR_W    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       done_i,
  input  logic signed [SAMPLE_W-1:0] avg_i,
  input  dcm_pkg::dc_mode_e          mode_i,
  input  logic [THR_W-1:0]           thr_hi_i,
  input  logic [THR_W-1:0]           thr_lo_i,
  input  logic                       int_mode_i,
  input  logic                       int_read_i,
  output logic [RES_W-1:0]           res_o,
  output logic                       hi_o,
  output logic                       lo_o,
  output logic                       irq_o
);
  localparam int D_W = SAMPLE_W + 1;
  localparam logic signed [D_W-1:0] SAT_HI = D_W'((1 << (RES_W-1)) - 1);
  localparam logic signed [D_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [SAMPLE_W-1:0] ref_q;
  logic signed [D_W-1:0]      diff;
  logic [RES_W-1:0]           res_n, mag;
  logic                       hi_n, lo_n, is_line, is_ref, changed, set_irq;

  assign is_line = (mode_i == dcm_pkg::MODE_LINE);
  assign is_ref  = (mode_i == dcm_pkg::MODE_REF);
  assign diff    = {avg_i[SAMPLE_W-1], avg_i} - {ref_q[SAMPLE_W-1], ref_q};

  always_comb begin
    if (diff > SAT_HI)      res_n = SAT_HI[RES_W-1:0];
    else if (diff < SAT_LO) res_n = SAT_LO[RES_W-1:0];
    else                    res_n = diff[RES_W-1:0];
    mag  = res_n[RES_W-1] ? (~res_n + 1'b1) : res_n;
    hi_n = (mag >= RES_W'(thr_hi_i));
    lo_n = (mag >= RES_W'(thr_lo_i));
  end

  assign changed = is_line & ((hi_n != hi_o) | (lo_n != lo_o));
  assign set_irq = done_i & (int_mode_i ? (is_line | is_ref) : changed);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      res_o <= '0;
      hi_o  <= 1'b0;
      lo_o  <= 1'b1;
      irq_o <= 1'b0;
    end else begin
      if (done_i && is_line) begin
        res_o <= res_n;
        hi_o  <= hi_n;
        lo_o  <= lo_n;
      end
      if (done_i && is_ref) ref_q <= avg_i;
      if (set_irq)         irq_o <= 1'b1;
      else if (int_read_i) irq_o <= 1'b0;
    end
  end

  assert_cal_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && is_ref) |=> ($stable(res_o) && $stable(hi_o) && $stable(lo_o)));
  assert_rsv_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !is_line && !is_ref && !irq_o) |=>
      (!irq_o && $stable(res_o) && $stable(ref_q)));
  assert_change_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && is_line && (hi_n != hi_o)) |=> irq_o);
  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_read_i && !done_i) |=> !irq_o);
endmodule

// File: rtl/dc_level_monitor.sv
module dc_level_monitor #(
  parameter int SAMPLE_W = 10,
  parameter int WIN_W    = 8,
  parameter int THR_W    = 8,
  parameter int RES_W    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [WIN_W-1:0]    window_i,
  input  logic [THR_W-1:0]    thr_hi_i,
  input  logic [THR_W-1:0]    thr_lo_i,
  input  logic [1:0]          mode_i,
  input  logic                int_mode_i,
  input  logic                int_read_i,
  output logic [RES_W-2:0]    res_lo_o,
  output logic                res_sign_o,
  output logic                stat_hi_o,
  output logic                stat_lo_o,
  output logic                irq_o
);
  localparam int SH_W = $clog2(WIN_W);

  logic                       accept, first, last, done;
  logic [SH_W-1:0]            shift_q;
  logic [THR_W-1:0]           thr_hi_q, thr_lo_q;
  dcm_pkg::dc_mode_e          mode_q;
  logic signed [SAMPLE_W-1:0] avg;
  logic [RES_W-1:0]           res;

  dcm_window_ctrl #(.WIN_W(WIN_W), .THR_W(THR_W), .SH_W(SH_W)) i_ctrl (
    .clk_i, .rst_ni, .en_i, .valid_i(sample_valid_i), .window_i,
    .thr_hi_i, .thr_lo_i, .mode_i,
    .accept_o(accept), .first_o(first), .last_o(last), .shift_q_o(shift_q),
    .thr_hi_q_o(thr_hi_q), .thr_lo_q_o(thr_lo_q), .mode_q_o(mode_q)
  );

  dcm_accum #(.SAMPLE_W(SAMPLE_W), .WIN_W(WIN_W), .SH_W(SH_W)) i_accum (
    .clk_i, .rst_ni, .accept_i(accept), .first_i(first), .last_i(last),
    .sample_i, .shift_i(shift_q), .avg_o(avg), .done_o(done)
  );

  dcm_result #(.SAMPLE_W(SAMPLE_W), .RES_W(RES_W), .THR_W(THR_W)) i_result (
    .clk_i, .rst_ni, .done_i(done), .avg_i(avg), .mode_i(mode_q),
    .thr_hi_i(thr_hi_q), .thr_lo_i(thr_lo_q), .int_mode_i, .int_read_i,
    .res_o(res), .hi_o(stat_hi_o), .lo_o(stat_lo_o), .irq_o
  );

  assign res_lo_o   = res[RES_W-2:0];
  assign res_sign_o = res[RES_W-1];
endmodule

// File: tb/test_dc_level_monitor.sv
`timescale 1ns/1ps
module test_dc_level_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, valid = 1'b0, int_mode = 1'b0, int_read = 1'b0;
  logic [9:0] sample = '0;
  logic [7:0] window = 8'd4, thr_hi = 8'd150, thr_lo = 8'd50;
  logic [1:0] mode = 2'b00;
  logic [7:0] res_lo;
  logic       res_sign, st_hi, st_lo, irq;

  always #2 clk = ~clk;

  dc_level_monitor i_dc_level_monitor (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sample_valid_i(valid),
    .sample_i(sample), .window_i(window), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
    .mode_i(mode), .int_mode_i(int_mode), .int_read_i(int_read),
    .res_lo_o(res_lo), .res_sign_o(res_sign), .stat_hi_o(st_hi),
    .stat_lo_o(st_lo), .irq_o(irq)
  );

  typedef struct { int res; bit hi; bit lo; bit irq; string tag; } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  int ref_m = 0, res_m = 0;
  bit hi_m = 0, lo_m = 1, irq_m = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: one item per finished window, sampled just after the update edge
  initial forever begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(res_lo == 8'(e.res), e.tag, "res_lo", int'(res_lo), e.res & 255);
      check(res_sign == (e.res < 0), e.tag, "sign", int'(res_sign), int'(e.res < 0));
      check(st_hi == e.hi, e.tag, "stat_hi", int'(st_hi), int'(e.hi));
      check(st_lo == e.lo, e.tag, "stat_lo", int'(st_lo), int'(e.lo));
      check(irq == e.irq, e.tag, "irq", int'(irq), int'(e.irq));
    end
  end

  // driver: one full window, first sample v0, the rest v1
  task automatic run_win(input int win, input int v0, input int v1,
                         input int mid_hi, input string tag);
    int sh = 1, len, sum, avg, d, mag;
    bit nh, nl, ch = 0;
    int th = int'(thr_hi), tl = int'(thr_lo), md = int'(mode);
    bit im = int_mode;
    exp_t e;
    for (int i = 1; i < 8; i++) if (((win >> i) & 1) != 0) sh = i;
    len = 1 << sh;
    window = 8'(win);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid  = 1'b1;
      sample = 10'((i == 0) ? v0 : v1);
      if (i == 1 && mid_hi >= 0) thr_hi = 8'(mid_hi);
    end
    @(negedge clk);
    valid = 1'b0;
    sum = v0 + (len - 1) * v1;
    avg = sum >>> sh;
    if (md == 0) begin
      d = avg - ref_m;
      if (d > 255) d = 255;
      if (d < -256) d = -256;
      mag = (d < 0) ? -d : d;
      nh = (mag >= th);
      nl = (mag >= tl);
      ch = (nh != hi_m) || (nl != lo_m);
      res_m = d; hi_m = nh; lo_m = nl;
    end else if (md == 1) begin
      ref_m = avg;
    end
    if (im ? (md < 2) : ch) irq_m = 1;
    e.res = res_m; e.hi = hi_m; e.lo = lo_m; e.irq = irq_m; e.tag = tag;
    sb_q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_irq(input string tag);
    @(negedge clk); int_read = 1'b1;
    @(negedge clk); int_read = 1'b0;
    irq_m = 0;
    check(irq == 1'b0, tag, "irq after read", int'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    check(res_lo == 0 && res_sign == 0, "R4", "reset result", int'(res_lo), 0);
    check(st_hi == 0, "R4", "reset stat_hi", int'(st_hi), 0);
    check(st_lo == 1, "R4", "reset stat_lo", int'(st_lo), 1);
    check(irq == 0, "R4", "reset irq", int'(irq), 0);

    run_win(4, 100, 100, -1, "R1 R2 R3 R7 no change");
    run_win(8, 200, 200, -1, "R3 R7 change");
    read_irq("R9");
    int_mode = 1'b1;
    run_win(8, 200, 200, -1, "R8 every result");
    read_irq("R9");
    mode = 2'b01;
    run_win(2, 30, 31, -1, "R5 reference");
    read_irq("R9");
    mode = 2'b00; int_mode = 1'b0;
    run_win(16, -10, -11, -1, "R2 negative floor");
    read_irq("R9");
    run_win(2, 500, 500, -1, "R2 saturate high");
    read_irq("R9");
    run_win(2, -500, -500, -1, "R2 R3 saturate low");
    run_win(12, 100, 100, -1, "R1 non-power window");
    read_irq("R9");
    run_win(0, 100, 100, -1, "R1 zero window");
    thr_hi = 8'd250; thr_lo = 8'd10;
    run_win(4, 100, 100, 5, "R10 mid-window threshold");
    thr_hi = 8'd150; thr_lo = 8'd50;
    run_win(4, 100, 100, -1, "R3 thresholds restored");
    read_irq("R9");
    int_mode = 1'b1; mode = 2'b10;
    run_win(4, 300, 300, -1, "R6 reserved 10");
    mode = 2'b11;
    run_win(4, -300, -300, -1, "R6 reserved 11");
    mode = 2'b00; int_mode = 1'b0;
    // R11 samples while disabled are ignored
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); valid = 1'b1; sample = 10'd400;
    end
    @(negedge clk); valid = 1'b0; en = 1'b1;
    run_win(2, 20, 20, -1, "R11 disabled samples");
    read_irq("R9");
    // R11 partial window abandoned
    window = 8'd4;
    @(negedge clk); valid = 1'b1; sample = 10'd400;
    @(negedge clk); valid = 1'b0; en = 1'b0;
    @(negedge clk); en = 1'b1;
    run_win(4, 20, 20, -1, "R11 partial window dropped");
    run_win(128, 3, 4, -1, "R1 R2 max window");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule